// File: doc/BRIEF.md
# Errored-Second Performance Classifier

This block counts error-event strobes from a line framer over a repeating measurement interval. At the end of each interval it compares the event total with three programmable thresholds. It then classifies the interval as an errored second (ES), a severely errored second (SES) or a bursty errored second (BES). Any combination of the three can apply to one interval.

Each classification is given as a single-cycle pulse that comes with an end-of-interval strobe. Saturating tallies keep a running count of the intervals in each class. The thresholds and the interval length are set through a byte-wide register write port.

New settings are held in staging registers and only take effect at an interval boundary. The 16-bit SES threshold is loaded as one atomic pair.

Top module: `err_sec_classifier`

## Requirements
- R1: The interval length is selected by bits 1:0 at address 4. 00 selects CLK_HZ cycles, 01 selects CLK_HZ/2, 10 selects CLK_HZ/10 and 11 selects TEST_CYCLES. The select is 00 after reset. Each interval ends with a one-cycle `eoi_o` pulse in the first cycle of the next interval, so consecutive pulses are exactly one interval apart.
- R2: The ES threshold is written at address 0. `es_o` pulses with `eoi_o` when the interval's event count is greater than or equal to a nonzero ES threshold.
- R3: The SES threshold is 16 bits wide, with its high byte at address 1 and its low byte at address 2. `ses_o` pulses with `eoi_o` when the count is greater than or equal to a nonzero SES threshold.
- R4: The BES threshold is written at address 3. `bes_o` pulses with `eoi_o` when the count is greater than or equal to a nonzero BES threshold.
- R5: A threshold of zero disables its class, so that class never flags an interval, whatever the count.
- R6: The three classes are judged independently, and a flag is only ever asserted together with `eoi_o`.
- R7: A threshold or select written during an interval does not affect the judgement of that interval. It applies from the next interval on.
- R8: A high-byte SES write is only staged. The following low-byte write commits both bytes together, so a half-updated 16-bit threshold is never used.
- R9: The event count saturates at 0xFFFF and restarts from zero in every interval. A count from one interval never carries into the next.
- R10: `es_cnt_o`, `ses_cnt_o` and `bes_cnt_o` each increase by one per flagged interval of their class and saturate at all ones.
- R11: `clr_i` synchronously clears all three tallies.
- R12: After reset, all flags, `eoi_o` and all tallies are zero, and all thresholds are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| evt_i | input | 1 | Error-event strobe, one event per high cycle |
| clr_i | input | 1 | Synchronous clear of the tallies |
| eoi_o | output | 1 | End-of-interval pulse |
| es_o | output | 1 | Errored-second flag |
| ses_o | output | 1 | Severely-errored-second flag |
| bes_o | output | 1 | Bursty-errored-second flag |
| es_cnt_o | output | TALLY_W | ES interval tally |
| ses_cnt_o | output | TALLY_W | SES interval tally |
| bes_cnt_o | output | TALLY_W | BES interval tally |

## Verification
The hardest case to reach is a split SES threshold in which only the high byte has been written. It has to be shown that the pending byte leaves the next judgement unchanged, and that the value committed by the low-byte write is honoured exactly at the 256-event edge. The stimulus aligns itself to each `eoi_o` pulse, so writes and event bursts land in known intervals. The bench uses a short test interval and a reduced clock-rate parameter to reach every interval length. It also uses a narrow tally width so that saturation can be reached.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam logic [2:0] ADDR_ES     = 3'd0;
  localparam logic [2:0] ADDR_SES_HI = 3'd1;
  localparam logic [2:0] ADDR_SES_LO = 3'd2;
  localparam logic [2:0] ADDR_BES    = 3'd3;
  localparam logic [2:0] ADDR_SEL    = 3'd4;

  localparam int EVT_W  = 16;
  localparam int NCLASS = 3;
  localparam int CLS_ES  = 0;
  localparam int CLS_SES = 1;
  localparam int CLS_BES = 2;

  typedef enum logic [1:0] {
    IVL_FULL  = 2'b00,
    IVL_HALF  = 2'b01,
    IVL_TENTH = 2'b10,
    IVL_TEST  = 2'b11
  } ivl_sel_e;
endpackage

// File: rtl/esc_timer.sv
module esc_timer
  import esc_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int TEST_CYCLES = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ivl_sel_e sel_i,
  output logic     tick_o
);
  localparam int CW = $clog2(CLK_HZ + 1);

  logic [CW-1:0] cnt_q, lim;

  always_comb begin
    unique case (sel_i)
      IVL_FULL:  lim = CW'(CLK_HZ);
      IVL_HALF:  lim = CW'(CLK_HZ / 2);
      IVL_TENTH: lim = CW'(CLK_HZ / 10);
      default:   lim = CW'(TEST_CYCLES);
    endcase
  end

  assign tick_o = (cnt_q == lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1: an interval is never a single cycle long
  a_r1_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/esc_thresh_regs.sv
module esc_thresh_regs
  import esc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             tick_i,
  output logic [7:0]       es_thr_o,
  output logic [EVT_W-1:0] ses_thr_o,
  output logic [7:0]       bes_thr_o,
  output ivl_sel_e         sel_o
);
  logic [7:0]       es_stg, bes_stg, ses_hi_stg;
  logic [EVT_W-1:0] ses_stg;
  ivl_sel_e         sel_stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      es_stg     <= '0;
      bes_stg    <= '0;
      ses_hi_stg <= '0;
      ses_stg    <= '0;
      sel_stg    <= IVL_FULL;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_ES:     es_stg     <= wr_data_i;
        ADDR_SES_HI: ses_hi_stg <= wr_data_i;
        ADDR_SES_LO: ses_stg    <= {ses_hi_stg, wr_data_i}; // pair commit
        ADDR_BES:    bes_stg    <= wr_data_i;
        ADDR_SEL:    sel_stg    <= ivl_sel_e'(wr_data_i[1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      es_thr_o  <= '0;
      ses_thr_o <= '0;
      bes_thr_o <= '0;
      sel_o     <= IVL_FULL;
    end else if (tick_i) begin
      es_thr_o  <= es_stg;
      ses_thr_o <= ses_stg;
      bes_thr_o <= bes_stg;
      sel_o     <= sel_stg;
    end
  end

  // R7: active settings move only at a boundary
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(es_thr_o) && $stable(bes_thr_o) && $stable(sel_o)));
  // R8: the 16-bit SES threshold changes only at a boundary
  a_r8_ses_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ses_thr_o));
endmodule

// File: rtl/esc_tally.sv
module esc_tally #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end

  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  a_r10_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o && !clr_i) |=> &cnt_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/err_sec_classifier.sv
module err_sec_classifier
  import esc_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int TEST_CYCLES = 64,
  parameter int TALLY_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               evt_i,
  input  logic               clr_i,
  output logic               eoi_o,
  output logic               es_o,
  output logic               ses_o,
  output logic               bes_o,
  output logic [TALLY_W-1:0] es_cnt_o,
  output logic [TALLY_W-1:0] ses_cnt_o,
  output logic [TALLY_W-1:0] bes_cnt_o
);
  logic             tick;
  ivl_sel_e         sel;
  logic [7:0]       es_thr, bes_thr;
  logic [EVT_W-1:0] ses_thr;
  logic [EVT_W-1:0] evt_cnt_q, evt_nxt;
  logic [NCLASS-1:0] hit, flag_q;
  logic [TALLY_W-1:0] tally [NCLASS];

  esc_timer #(.CLK_HZ(CLK_HZ), .TEST_CYCLES(TEST_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .tick_o(tick)
  );

  esc_thresh_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .tick_i(tick), .es_thr_o(es_thr),
    .ses_thr_o(ses_thr), .bes_thr_o(bes_thr), .sel_o(sel)
  );

  // count including an event in the boundary cycle
  assign evt_nxt = (&evt_cnt_q) ? evt_cnt_q : evt_cnt_q + {{(EVT_W-1){1'b0}}, evt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   evt_cnt_q <= '0;
    else if (tick) evt_cnt_q <= '0;
    else           evt_cnt_q <= evt_nxt;
  end

  assign hit[CLS_ES]  = (es_thr  != '0) && (evt_nxt >= {8'h00, es_thr});
  assign hit[CLS_SES] = (ses_thr != '0) && (evt_nxt >= ses_thr);
  assign hit[CLS_BES] = (bes_thr != '0) && (evt_nxt >= {8'h00, bes_thr});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoi_o  <= 1'b0;
      flag_q <= '0;
    end else begin
      eoi_o  <= tick;
      flag_q <= tick ? hit : '0;
    end
  end

  assign es_o  = flag_q[CLS_ES];
  assign ses_o = flag_q[CLS_SES];
  assign bes_o = flag_q[CLS_BES];

  for (genvar g = 0; g < NCLASS; g++) begin : g_tally
    esc_tally #(.W(TALLY_W)) u_tally (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
      .inc_i(tick & hit[g]), .cnt_o(tally[g])
    );
  end

  assign es_cnt_o  = tally[CLS_ES];
  assign ses_cnt_o = tally[CLS_SES];
  assign bes_cnt_o = tally[CLS_BES];

  a_r1_eoi_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |=> !eoi_o);
  a_r6_flag_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (es_o || ses_o || bes_o) |-> eoi_o);
  a_r5_es_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (es_thr == '0) |=> !es_o);
  a_r5_ses_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ses_thr == '0) |=> !ses_o);
  a_r5_bes_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bes_thr == '0) |=> !bes_o);
  a_r9_evt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&evt_cnt_q && !tick) |=> &evt_cnt_q);
  a_r9_evt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (evt_cnt_q == '0));
endmodule

// File: tb/err_sec_classifier_test.sv
module err_sec_classifier_test;
  localparam int CLK_HZ = 1000;
  localparam int TEST_CYCLES = 300;
  localparam int TW = 4;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, evt_i = 1'b0, clr_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic eoi_o, es_o, ses_o, bes_o;
  logic [TW-1:0] es_cnt_o, ses_cnt_o, bes_cnt_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_eoi = 0, gap = 0;
  int exp_es = 0, exp_ses = 0, exp_bes = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  err_sec_classifier #(.CLK_HZ(CLK_HZ), .TEST_CYCLES(TEST_CYCLES), .TALLY_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .evt_i(evt_i), .clr_i(clr_i), .eoi_o(eoi_o),
    .es_o(es_o), .ses_o(ses_o), .bes_o(bes_o), .es_cnt_o(es_cnt_o),
    .ses_cnt_o(ses_cnt_o), .bes_cnt_o(bes_cnt_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // waits at negedges for eoi_o; returns flags and gap since previous pulse
  task automatic wait_eoi(output logic [2:0] fl);
    int t = 0;
    @(negedge clk);
    while (!eoi_o && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(eoi_o, "R1 eoi timeout", t, 0);
    fl = {bes_o, ses_o, es_o};
    gap = cyc - last_eoi;
    last_eoi = cyc;
  endtask

  function automatic int sat_inc(input int v);
    return (v >= TMAX) ? TMAX : v + 1;
  endfunction

  // called just after an eoi; n events, then judge the interval
  task automatic classify(input int n, input bit e, input bit s, input bit b, input string req);
    logic [2:0] fl;
    for (int i = 0; i < n; i++) begin
      evt_i = 1'b1;
      @(negedge clk);
    end
    evt_i = 1'b0;
    wait_eoi(fl);
    check(fl[0] == e, {req, " es_o"}, int'(fl[0]), int'(e));
    check(fl[1] == s, {req, " ses_o"}, int'(fl[1]), int'(s));
    check(fl[2] == b, {req, " bes_o"}, int'(fl[2]), int'(b));
    if (e) exp_es = sat_inc(exp_es);
    if (s) exp_ses = sat_inc(exp_ses);
    if (b) exp_bes = sat_inc(exp_bes);
    check(int'(es_cnt_o) == exp_es, "R10 es tally", int'(es_cnt_o), exp_es);
    check(int'(ses_cnt_o) == exp_ses, "R10 ses tally", int'(ses_cnt_o), exp_ses);
    check(int'(bes_cnt_o) == exp_bes, "R10 bes tally", int'(bes_cnt_o), exp_bes);
  endtask

  task automatic t_reset();
    check({eoi_o, es_o, ses_o, bes_o} == 4'b0, "R12 flags", int'({eoi_o, es_o, ses_o, bes_o}), 0);
    check(es_cnt_o == '0 && ses_cnt_o == '0 && bes_cnt_o == '0, "R12 tallies",
          int'(es_cnt_o) + int'(ses_cnt_o) + int'(bes_cnt_o), 0);
  endtask

  task automatic t_deferred();
    logic [2:0] fl;
    wr(3'd0, 8'd3); wr(3'd1, 8'd0); wr(3'd2, 8'd5); wr(3'd3, 8'd2); wr(3'd4, 8'd3);
    for (int i = 0; i < 10; i++) begin
      evt_i = 1'b1;
      @(negedge clk);
    end
    evt_i = 1'b0;
    wait_eoi(fl);
    check(fl == 3'b000, "R7 old zero thresholds", int'(fl), 0);
    check(gap == CLK_HZ, "R1 1 s interval", gap, CLK_HZ);
    @(negedge clk);
    check(!eoi_o, "R1 eoi single cycle", int'(eoi_o), 0);
    wait_eoi(fl);
    check(gap == TEST_CYCLES, "R1 test interval", gap, TEST_CYCLES);
  endtask

  task automatic t_classes();
    classify(0, 0, 0, 0, "R6 no events");
    classify(2, 0, 0, 1, "R4 bes only");
    classify(3, 1, 0, 1, "R2 es at threshold");
    classify(5, 1, 1, 1, "R3 all three");
    classify(2, 0, 0, 1, "R9 count restarts");
  endtask

  task automatic t_ses_pair();
    wr(3'd1, 8'd1);
    classify(5, 1, 1, 1, "R8 high byte only staged");
    wr(3'd2, 8'd0);
    classify(5, 1, 1, 1, "R7 pair pending");
    classify(255, 1, 0, 1, "R3 below 0x0100");
    classify(256, 1, 1, 1, "R3 at 0x0100");
  endtask

  task automatic t_disable();
    wr(3'd0, 8'd0); wr(3'd3, 8'd0);
    classify(0, 0, 0, 0, "R5 apply");
    classify(10, 0, 0, 0, "R5 es/bes disabled");
    wr(3'd1, 8'd0); wr(3'd2, 8'd0);
    classify(0, 0, 0, 0, "R5 apply ses");
    classify(20, 0, 0, 0, "R5 all disabled");
  endtask

  task automatic t_saturate();
    wr(3'd0, 8'd1);
    classify(0, 0, 0, 0, "R10 apply");
    for (int i = 0; i < TMAX + 2; i++) classify(1, 1, 0, 0, "R10 saturation");
  endtask

  task automatic t_clear();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    check(es_cnt_o == '0 && ses_cnt_o == '0 && bes_cnt_o == '0, "R11 clear",
          int'(es_cnt_o) + int'(ses_cnt_o) + int'(bes_cnt_o), 0);
    exp_es = 0; exp_ses = 0; exp_bes = 0;
  endtask

  task automatic t_periods();
    logic [2:0] fl;
    wr(3'd4, 8'd2);
    wait_eoi(fl);
    wait_eoi(fl);
    check(gap == CLK_HZ / 10, "R1 tenth interval", gap, CLK_HZ / 10);
    wr(3'd4, 8'd1);
    wait_eoi(fl);
    check(gap == CLK_HZ / 10, "R7 select deferred", gap, CLK_HZ / 10);
    wait_eoi(fl);
    check(gap == CLK_HZ / 2, "R1 half interval", gap, CLK_HZ / 2);
    wr(3'd4, 8'd0);
    wait_eoi(fl);
    wait_eoi(fl);
    check(gap == CLK_HZ, "R1 full interval", gap, CLK_HZ);
  endtask

  initial begin
    #(200_000 * 8);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    last_eoi = cyc;
    t_reset();
    t_deferred();
    t_classes();
    t_ses_pair();
    t_disable();
    t_saturate();
    t_clear();
    t_periods();
    finish_run();
  end
endmodule